// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block derives two groups of divided clocks from a single input clock. Group A runs at one half or one quarter of the input frequency. Group B runs at one quarter or one sixth of it. Each group has its own ratio select, and each provides a true output and an inverted output. One shared phase counter, clocked on the rising input edge, drives both groups. Every rising or falling edge that the two groups have in common therefore happens on the same input edge. Each output is taken straight from a flip-flop, so no output can glitch.

A shared enable is captured on the falling input edge. The dividers start only from a state in which every output is low. A divider that is running stops only when its common period ends, which is the point where all outputs are low together. Because of this, no output ever carries a shortened high or low phase. A new ratio selection is loaded at the same period boundaries. An asynchronous master reset forces every output low. This lets several instances be released in step: each one starts its outputs on the first rising edge after it has seen the enable.

Top module: `cdiv_dual`

## Requirements
- R1: While `mrst` is high, `qa` and `qb` are low and `qa_n` and `qb_n` are high, starting at once and with no clock edge needed. The enable capture flop is also cleared.
- R2: Group A toggles on every input rising edge when its active select is 0 (divide by 2). When its active select is 1 it stays high for 2 input cycles and then low for 2 (divide by 4).
- R3: Group B stays high for 2 input cycles and low for 2 when its active select is 0 (divide by 4). When its active select is 1 it stays high for exactly 3 input cycles and low for exactly 3 (divide by 6).
- R4: `qa_n` is always the inverse of `qa`, and `qb_n` is always the inverse of `qb`.
- R5: `en` is sampled only on the falling edge of `clk_in`. From the stopped state, the outputs first rise on the first rising edge that follows a falling edge at which `en` was high.
- R6: When the dividers start, `qa` and `qb` rise on the same rising edge. A common period ends and a new one begins on the same edge for both groups.
- R7: If `en` is sampled low while the dividers run, they finish the current common period and then stop. After that, all true outputs stay low while `en` remains low.
- R8: A change on `sel_a` or `sel_b` takes effect only at the start of a common period, where both groups begin high together. The common period is 4, 4, 6 or 12 input cycles for the select pairs (0,0), (1,0), (0,1) and (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock that is divided |
| mrst | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Shared run enable, sampled on the falling edge |
| sel_a | input | 1 | Group A ratio: 0 divides by 2, 1 divides by 4 |
| sel_b | input | 1 | Group B ratio: 0 divides by 4, 1 divides by 6 |
| qa | output | 1 | Group A divided clock |
| qa_n | output | 1 | Group A divided clock, inverted |
| qb | output | 1 | Group B divided clock |
| qb_n | output | 1 | Group B divided clock, inverted |

## Verification
A phase counter that slips, or wraps at the wrong count, shows up on the outputs within one common period, which is at most twelve input cycles. It appears as a high or low phase of the wrong length, or as the two groups losing their common edge. A select register that loads in the middle of a period, or an enable that is sampled on the wrong edge, moves the first output edge by one input cycle on the very next rising edge. The bench compares against a behavioural model on every cycle, so this one-cycle shift is caught as soon as it happens.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Greatest common divisor of two positive ratios.
    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple: the length of one common period.
    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    function automatic int max2_f(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Run flag plus the two ratio selections currently in force.
    typedef struct packed {
        logic run;
        logic sa;
        logic sb;
    } ctl_t;

endpackage

// File: rtl/cdiv_en_capture.sv
module cdiv_en_capture (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic en_q
);
    logic en_d;

    always_comb begin
        en_d = en;
    end

    // Captured on the falling edge, so the value is settled
    // before the next rising edge decides to start or stop.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
    end
endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase
    import cdiv_pkg::*;
#(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_LO = 4,
    parameter int B_HI = 6,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_q,
    input  logic          sel_a,
    input  logic          sel_b,
    output logic          run_d,
    output logic          sa_d,
    output logic          sb_d,
    output logic [CW-1:0] cnt_d,
    output logic          run_q
);
    // Last count value of the common period for each select pair.
    localparam logic [CW-1:0] LAST_00 = CW'(lcm_f(A_LO, B_LO) - 1);
    localparam logic [CW-1:0] LAST_10 = CW'(lcm_f(A_HI, B_LO) - 1);
    localparam logic [CW-1:0] LAST_01 = CW'(lcm_f(A_LO, B_HI) - 1);
    localparam logic [CW-1:0] LAST_11 = CW'(lcm_f(A_HI, B_HI) - 1);

    typedef struct packed {
        ctl_t          ctl;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d;
    st_t  st_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        unique case ({st_q.ctl.sa, st_q.ctl.sb})
            2'b00:   last = LAST_00;
            2'b10:   last = LAST_10;
            2'b01:   last = LAST_01;
            default: last = LAST_11;
        endcase
        wrap = st_q.ctl.run && (st_q.cnt == last);

        st_d = st_q;
        if (!st_q.ctl.run) begin
            // Stopped: every output is already low, so starting is safe.
            if (en_q) begin
                st_d.ctl.run = 1'b1;
                st_d.ctl.sa  = sel_a;
                st_d.ctl.sb  = sel_b;
                st_d.cnt     = '0;
            end
        end else if (wrap) begin
            // Common boundary: all outputs low together.
            st_d.cnt = '0;
            if (en_q) begin
                st_d.ctl.sa = sel_a;
                st_d.ctl.sb = sel_b;
            end else begin
                st_d.ctl.run = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign run_d = st_d.ctl.run;
    assign sa_d  = st_d.ctl.sa;
    assign sb_d  = st_d.ctl.sb;
    assign cnt_d = st_d.cnt;
    assign run_q = st_q.ctl.run;

    // R2/R3: the counter never passes the end of its common period.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.ctl.run |-> (st_q.cnt <= last));

    // R8: the active selection cannot change inside a period.
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctl.run && !wrap) |=> ($stable(st_q.ctl.sa) && $stable(st_q.ctl.sb)));

    // R5: a start follows a falling-edge sample of the enable.
    p_start_en_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.ctl.run) |-> $past(en_q));
endmodule

// File: rtl/cdiv_tap.sv
module cdiv_tap #(
    parameter int LO = 2,
    parameter int HI = 4,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_d,
    input  logic          sel_d,
    input  logic [CW-1:0] cnt_d,
    output logic          q_q
);
    localparam logic [CW-1:0] LO_W   = CW'(LO);
    localparam logic [CW-1:0] HI_W   = CW'(HI);
    localparam logic [CW-1:0] LO_HLF = CW'(LO / 2);
    localparam logic [CW-1:0] HI_HLF = CW'(HI / 2);

    logic high_lo;
    logic high_hi;
    logic q_d;

    // High during the first half of each output period.
    always_comb begin
        high_lo = (cnt_d % LO_W) < LO_HLF;
    end

    generate
        if (LO == HI) begin : g_fixed
            always_comb high_hi = high_lo;
        end else begin : g_two
            always_comb high_hi = (cnt_d % HI_W) < HI_HLF;
        end
    endgenerate

    always_comb begin
        q_d = run_d && (sel_d ? high_hi : high_lo);
    end

    // The output comes straight from a flop, so it cannot glitch.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) q_q <= 1'b0;
        else     q_q <= q_d;
    end
endmodule

// File: rtl/cdiv_dual.sv
module cdiv_dual
    import cdiv_pkg::*;
#(
    parameter int A_LO = 2,
    parameter int A_HI = 4,
    parameter int B_LO = 4,
    parameter int B_HI = 6
) (
    input  logic clk_in,
    input  logic mrst,
    input  logic en,
    input  logic sel_a,
    input  logic sel_b,
    output logic qa,
    output logic qa_n,
    output logic qb,
    output logic qb_n
);
    localparam int PMAX = max2_f(max2_f(lcm_f(A_LO, B_LO), lcm_f(A_HI, B_LO)),
                                 max2_f(lcm_f(A_LO, B_HI), lcm_f(A_HI, B_HI)));
    localparam int CW   = $clog2(PMAX + 1);

    logic          en_q;
    logic          run_d;
    logic          run_q;
    logic          sa_d;
    logic          sb_d;
    logic [CW-1:0] cnt_d;
    logic          qa_q;
    logic          qb_q;

    cdiv_en_capture u_en (
        .clk  (clk_in),
        .rst  (mrst),
        .en   (en),
        .en_q (en_q)
    );

    cdiv_phase #(
        .A_LO (A_LO), .A_HI (A_HI), .B_LO (B_LO), .B_HI (B_HI), .CW (CW)
    ) u_phase (
        .clk   (clk_in),
        .rst   (mrst),
        .en_q  (en_q),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .run_d (run_d),
        .sa_d  (sa_d),
        .sb_d  (sb_d),
        .cnt_d (cnt_d),
        .run_q (run_q)
    );

    cdiv_tap #(.LO (A_LO), .HI (A_HI), .CW (CW)) u_tap_a (
        .clk   (clk_in),
        .rst   (mrst),
        .run_d (run_d),
        .sel_d (sa_d),
        .cnt_d (cnt_d),
        .q_q   (qa_q)
    );

    cdiv_tap #(.LO (B_LO), .HI (B_HI), .CW (CW)) u_tap_b (
        .clk   (clk_in),
        .rst   (mrst),
        .run_d (run_d),
        .sel_d (sb_d),
        .cnt_d (cnt_d),
        .q_q   (qb_q)
    );

    assign qa   = qa_q;
    assign qa_n = ~qa_q;
    assign qb   = qb_q;
    assign qb_n = ~qb_q;

    // R7: once stopped, both groups sit low.
    p_idle_low_r7: assert property (@(posedge clk_in) disable iff (mrst)
        !run_q |-> (!qa_q && !qb_q));

    // R6: both groups rise on the starting edge.
    p_start_rise_r6: assert property (@(posedge clk_in) disable iff (mrst)
        $rose(run_q) |-> (qa_q && qb_q));
endmodule

// File: tb/tb_cdiv_dual.sv
module tb_cdiv_dual;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic sa = 1'b0;
    logic sb = 1'b0;
    logic qa;
    logic qa_n;
    logic qb;
    logic qb_n;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    cdiv_dual dut (
        .clk_in (clk), .mrst (rst), .en (en), .sel_a (sa), .sel_b (sb),
        .qa (qa), .qa_n (qa_n), .qb (qb), .qb_n (qb_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model.
    bit m_en;
    bit m_run = 1'b0;
    int m_ph = 0;
    int m_pa = 2;
    int m_pb = 4;
    int m_per = 4;

    task automatic load_sel();
        m_pa = sa ? 4 : 2;
        m_pb = sb ? 6 : 4;
        for (int k = 1; k <= 64; k++) begin
            if ((k % m_pa == 0) && (k % m_pb == 0)) begin
                m_per = k;
                break;
            end
        end
    endtask

    always @(negedge clk or posedge rst) begin
        if (rst) m_en <= 1'b0;
        else     m_en <= en;
    end

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_run = 1'b0;
        end else if (!m_run) begin
            if (m_en) begin
                m_run = 1'b1;
                m_ph = 0;
                load_sel();
            end
        end else if (m_ph == m_per - 1) begin
            if (m_en) begin
                m_ph = 0;
                load_sel();
            end else begin
                m_run = 1'b0;
            end
        end else begin
            m_ph++;
        end
    end

    function automatic bit exp_a();
        return m_run && ((m_ph % m_pa) < (m_pa / 2));
    endfunction

    function automatic bit exp_b();
        return m_run && ((m_ph % m_pb) < (m_pb / 2));
    endfunction

    // Compare on every cycle, 5 ns after the rising edge.
    always @(posedge clk) begin
        #5;
        if (!done) begin
            chk(qa == exp_a(), tag, "qa", qa, exp_a());
            chk(qb == exp_b(), tag, "qb", qb, exp_b());
            chk((qa_n == ~qa) && (qb_n == ~qb), "R4", "complement",
                {qa, qa_n, qb, qb_n}, {qa, ~qa, qb, ~qb});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #7;
    endtask

    initial begin
        int hi;
        int lo;
        int bad;
        #25;
        chk(!qa && !qb && qa_n && qb_n, "R1", "outputs in reset",
            {qa, qa_n, qb, qb_n}, 4'b0101);
        #10 rst = 1'b0;

        // R5: enable set just after a falling edge; the start waits one more.
        tag = "R5";
        @(posedge clk);
        #12 en = 1'b1;
        @(posedge clk);
        #5 chk(!qa && !qb, "R5", "no start before falling-edge sample", {qa, qb}, 0);
        @(posedge clk);
        #5 chk(qa && qb, "R6", "both rise together", {qa, qb}, 3);

        tag = "R2";
        cyc(30);
        sa = 1'b1;
        tag = "R8";
        cyc(30);
        sb = 1'b1;
        tag = "R3";
        cyc(40);

        // R3: divide by 6 is three high and three low.
        hi = 0;
        lo = 0;
        for (int i = 0; i < 20 && qb !== 1'b0; i++) begin @(posedge clk); #5; end
        for (int i = 0; i < 20 && qb !== 1'b1; i++) begin @(posedge clk); #5; end
        for (int i = 0; i < 20 && qb === 1'b1; i++) begin hi++; @(posedge clk); #5; end
        for (int i = 0; i < 20 && qb === 1'b0; i++) begin lo++; @(posedge clk); #5; end
        chk(hi == 3, "R3", "div6 high length", hi, 3);
        chk(lo == 3, "R3", "div6 low length", lo, 3);

        cyc(1);
        sa = 1'b0;
        tag = "R2";
        cyc(30);
        sa = 1'b1;
        cyc(5);

        // R7: disable mid-period; the period drains, then outputs stay low.
        tag = "R7";
        en = 1'b0;
        cyc(14);
        bad = 0;
        for (int i = 0; i < 15; i++) begin
            @(posedge clk);
            #5 if (qa || qb) bad++;
        end
        chk(bad == 0, "R7", "outputs low while disabled", bad, 0);

        tag = "R5";
        #2 en = 1'b1;
        sb = 1'b0;
        cyc(20);

        // R1: asynchronous reset in the middle of a period.
        tag = "R1";
        @(posedge clk);
        #3 rst = 1'b1;
        #1 chk(!qa && !qb && qa_n && qb_n, "R1", "async reset outputs",
               {qa, qa_n, qb, qb_n}, 4'b0101);
        #10 rst = 1'b0;
        tag = "R6";
        cyc(20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule